// File: doc/BRIEF.md
# Remote Transmitter Session Sequencer

This block runs one transmit session of a battery-powered, button-operated remote. It rests idle until a button line rises. It then waits out a debounce interval and latches the button combination. After that it asks a downstream modulator for code words, one request per word. The modulator reports the end of each word, guard gap included, through a one-cycle done pulse. All of the sequencer's decisions about releases and time-outs are taken at those word boundaries. The one exception is a change of button combination, which takes effect at once.

For each word the sequencer tells the datapath which kind to build: a rolling word, or a fixed seed word used for secure learning. It also strobes the synchronization counter once per session when that session needs a fresh rolling value. The session can end in two ways. One is a release, after which a configurable minimum number of words has been completed. The other is a time-out, which can cut that minimum short. The sequencer also drives an optional RF-enable line and an active-low indicator LED that blinks during transmission. Every interval is counted in periods of a millisecond tick input, and the unit sizes are parameters, so a simulation can run with short timings.

Top module: `tx_session_seq`

## Requirements
- R1: A session begins only after the button lines have stayed non-zero for DB_MS consecutive tick periods. A shorter press produces no word request.
- R2: At reset, word_start=0, rf_en=0 and led_n=1. The first word_start of a session carries the latched button code on word_btn, which is never zero.
- R3: Once all buttons read zero at a word boundary, the session ends when the number of words completed with buttons released reaches 2^cfg_min_words, giving 1, 2, 4 or 8 words.
- R4: At a word boundary where the elapsed session time has reached the time-out, the session ends even while a button is held, and even if the release minimum is not yet complete. The time-out is TO_UNIT_MS × {1,4,16,32} for cfg_timeout = 0..3. A new session needs all buttons released first.
- R5: A different non-zero combination during a session pulses word_abort together with a new word_start. It re-latches the code and restarts the time-out window.
- R6: A word is a seed word (word_seed=1) only when the latched code equals cfg_seed_btn, where bit i stands for button line i. The value 0000 turns seed words off.
- R7: With a matching code and production mode not active, words are rolling until the session time reaches TO_UNIT_MS × {0,1,2,4} for cfg_seed_delay = 0..3. They are seed words from then on.
- R8: Once sync_cnt has exceeded SEED_LIMIT at any time since reset, seed words are refused while cfg_seed_limit=1. This holds even after the counter wraps to a small value.
- R9: In production mode (cfg_seed_prod=1), a matching code gives first 2^cfg_min_words rolling words and then seed words. After release the session ends once at least that many seed words have been sent. The mode is inactive once sync_cnt has exceeded SEED_LIMIT at any time.
- R10: cnt_inc pulses only together with a session's (or abort restart's) first word_start. It pulses unless the session is a pure seed session, meaning a seed match with zero delay and production mode not active.
- R11: With cfg_rfen_en=1, rf_en is high from the first word request until the boundary of the session's last word. With cfg_rfen_en=0 it stays low.
- R12: During a session led_n is low for LED_UNIT_MS tick periods (cfg_led_long=0) or twice that (cfg_led_long=1), then high for LED_OFF_MS, and the cycle repeats.
- R13: With batt_low=1 the LED stays dark for the whole session when cfg_blink_low=0. It lights for exactly one on-interval when cfg_blink_low=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| btn | input | 4 | Button lines, bit i = button i |
| word_done | input | 1 | Modulator: current word and its guard gap finished |
| sync_cnt | input | CNT_W | Current synchronization counter value |
| batt_low | input | 1 | Battery-low indication |
| cfg_min_words | input | 2 | Words after release: 2^value |
| cfg_timeout | input | 2 | Time-out select |
| cfg_seed_btn | input | 4 | Combination that requests seed words |
| cfg_seed_delay | input | 2 | Delay before seed words |
| cfg_seed_limit | input | 1 | Refuse seeds once counter has passed the limit |
| cfg_seed_prod | input | 1 | Production seed mode |
| cfg_rfen_en | input | 1 | Drive rf_en |
| cfg_led_long | input | 1 | Long LED on-interval |
| cfg_blink_low | input | 1 | Single flash when battery is low |
| word_start | output | 1 | Request for a new word (one cycle) |
| word_seed | output | 1 | Requested word is a seed word |
| word_abort | output | 1 | Current word aborted (one cycle) |
| word_btn | output | 4 | Latched button code |
| cnt_inc | output | 1 | Increment the synchronization counter (one cycle) |
| rf_en | output | 1 | RF stage enable |
| led_n | output | 1 | Indicator LED, active low |

## Verification
The bench builds the sequencer with DB_MS=3, TO_UNIT_MS=10, LED_UNIT_MS=2 and LED_OFF_MS=20, and pulses the tick on every second clock. With these values a 10-clock word lasts about 5 ms. The shortest time-out therefore expires within two or three words, and the shortest seed delay expires after about two words. All four time-out and minimum-word settings, the abort-driven restart of the time-out window, and several full LED on/off periods then fit in a few hundred cycles each. SEED_LIMIT keeps its default of 127, so the sticky limit is reached by driving sync_cnt above it and then back to a small value.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DEBOUNCE = 2'd1,
        ST_SEND     = 2'd2,
        ST_WAIT_REL = 2'd3
    } seq_state_e;

endpackage

// File: rtl/tx_seed_policy.sv
// Seed eligibility: button match, sticky counter limit, production mode.
module tx_seed_policy #(
    parameter int CNT_W      = 20,
    parameter int SEED_LIMIT = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] sync_cnt,
    input  logic [3:0]       code,
    input  logic [3:0]       cfg_seed_btn,
    input  logic             cfg_seed_limit,
    input  logic             cfg_seed_prod,
    input  logic             delay_on,
    output logic             seed_ok,
    output logic             prod_on,
    output logic             inc_req
);

    logic past_d, past_q, past_now;

    // counter has exceeded the limit now or at any time since reset
    assign past_now = past_q || (sync_cnt > CNT_W'(SEED_LIMIT));

    always_comb begin
        past_d = past_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) past_q <= 1'b0;
        else        past_q <= past_d;
    end

    assign seed_ok = (cfg_seed_btn != 4'b0000) && (code == cfg_seed_btn)
                     && !(cfg_seed_limit && past_now);
    assign prod_on = cfg_seed_prod && !past_now;
    assign inc_req = !seed_ok || prod_on || delay_on;

endmodule

// File: rtl/tx_led_blinker.sv
// Indicator LED: on-interval / off-interval cycle, battery-low single flash.
module tx_led_blinker #(
    parameter int LED_UNIT_MS = 50,
    parameter int LED_OFF_MS  = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic active,
    input  logic cfg_led_long,
    input  logic batt_low,
    input  logic cfg_blink_low,
    output logic led_n
);

    localparam int ON_MAX = 2 * LED_UNIT_MS;
    localparam int LW     = $clog2(((ON_MAX > LED_OFF_MS) ? ON_MAX : LED_OFF_MS) + 1);

    typedef struct packed {
        logic          act;
        logic          on_ph;
        logic          flashed;
        logic [LW-1:0] cnt;
    } led_t;

    led_t d, q;
    logic [LW-1:0] on_lim;

    always_comb begin
        on_lim = cfg_led_long ? LW'(ON_MAX) : LW'(LED_UNIT_MS);
        d      = q;
        d.act  = active;
        if (!active) begin
            d.on_ph   = 1'b0;
            d.flashed = 1'b0;
            d.cnt     = '0;
        end else if (!q.act) begin
            d.on_ph   = 1'b1;
            d.flashed = 1'b0;
            d.cnt     = '0;
        end else if (ms_tick) begin
            if (q.on_ph) begin
                if (q.cnt >= on_lim - 1'b1) begin
                    d.on_ph   = 1'b0;
                    d.flashed = 1'b1;
                    d.cnt     = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else begin
                if (q.cnt >= LW'(LED_OFF_MS - 1)) begin
                    d.on_ph = 1'b1;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign led_n = !(q.act && q.on_ph && (!batt_low || (cfg_blink_low && !q.flashed)));

endmodule

// File: rtl/tx_session_seq.sv
module tx_session_seq
    import tx_seq_pkg::*;
#(
    parameter int DB_MS       = 20,
    parameter int TO_UNIT_MS  = 800,
    parameter int LED_UNIT_MS = 50,
    parameter int LED_OFF_MS  = 500,
    parameter int CNT_W       = 20,
    parameter int SEED_LIMIT  = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic [3:0]       btn,
    input  logic             word_done,
    input  logic [CNT_W-1:0] sync_cnt,
    input  logic             batt_low,
    input  logic [1:0]       cfg_min_words,
    input  logic [1:0]       cfg_timeout,
    input  logic [3:0]       cfg_seed_btn,
    input  logic [1:0]       cfg_seed_delay,
    input  logic             cfg_seed_limit,
    input  logic             cfg_seed_prod,
    input  logic             cfg_rfen_en,
    input  logic             cfg_led_long,
    input  logic             cfg_blink_low,
    output logic             word_start,
    output logic             word_seed,
    output logic             word_abort,
    output logic [3:0]       word_btn,
    output logic             cnt_inc,
    output logic             rf_en,
    output logic             led_n
);

    localparam int DB_W   = $clog2(DB_MS + 1);
    localparam int TO_MAX = TO_UNIT_MS * 32;
    localparam int TO_W   = $clog2(TO_MAX + 1);
    localparam int WC_W   = 5;

    typedef struct packed {
        seq_state_e      st;
        logic [DB_W-1:0] db_cnt;
        logic [TO_W-1:0] to_cnt;
        logic [TO_W-1:0] sd_cnt;
        logic [3:0]      code;
        logic [WC_W-1:0] wcnt;
        logic [WC_W-1:0] rel_cnt;
        logic            start;
        logic            seed;
        logic            abort;
        logic            inc;
    } seq_t;

    seq_t d, q;

    logic [TO_W-1:0] to_lim, sd_lim;
    logic [WC_W-1:0] min_w, wc_nxt, rc_nxt;
    logic [3:0]      cand_code;
    logic            btn_new, seed_ok, prod_on, inc_req, launch, fin;

    // configuration-derived limits
    always_comb begin
        case (cfg_timeout)
            2'd0:    to_lim = TO_W'(TO_UNIT_MS);
            2'd1:    to_lim = TO_W'(TO_UNIT_MS * 4);
            2'd2:    to_lim = TO_W'(TO_UNIT_MS * 16);
            default: to_lim = TO_W'(TO_UNIT_MS * 32);
        endcase
        case (cfg_seed_delay)
            2'd0:    sd_lim = '0;
            2'd1:    sd_lim = TO_W'(TO_UNIT_MS);
            2'd2:    sd_lim = TO_W'(TO_UNIT_MS * 2);
            default: sd_lim = TO_W'(TO_UNIT_MS * 4);
        endcase
        min_w = WC_W'(1) << cfg_min_words;
    end

    assign btn_new   = (q.st == ST_SEND) && (btn != 4'b0000) && (btn != q.code);
    assign cand_code = ((q.st == ST_SEND) && !btn_new) ? q.code : btn;

    tx_seed_policy #(
        .CNT_W      (CNT_W),
        .SEED_LIMIT (SEED_LIMIT)
    ) u_policy (
        .clk            (clk),
        .rst_n          (rst_n),
        .sync_cnt       (sync_cnt),
        .code           (cand_code),
        .cfg_seed_btn   (cfg_seed_btn),
        .cfg_seed_limit (cfg_seed_limit),
        .cfg_seed_prod  (cfg_seed_prod),
        .delay_on       (cfg_seed_delay != 2'd0),
        .seed_ok        (seed_ok),
        .prod_on        (prod_on),
        .inc_req        (inc_req)
    );

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.abort = 1'b0;
        d.inc   = 1'b0;
        launch  = 1'b0;

        wc_nxt = (q.wcnt == '1) ? q.wcnt : q.wcnt + 1'b1;
        if (btn == 4'b0000 && q.rel_cnt != '1) rc_nxt = q.rel_cnt + 1'b1;
        else                                   rc_nxt = q.rel_cnt;
        if (seed_ok && prod_on)
            fin = (btn == 4'b0000) && (wc_nxt >= {min_w[WC_W-2:0], 1'b0});
        else
            fin = (btn == 4'b0000) && (rc_nxt >= min_w);

        case (q.st)
            ST_IDLE: begin
                if (btn != 4'b0000) begin
                    d.st     = ST_DEBOUNCE;
                    d.db_cnt = '0;
                end
            end
            ST_DEBOUNCE: begin
                if (btn == 4'b0000) begin
                    d.st = ST_IDLE;
                end else if (ms_tick) begin
                    if (q.db_cnt == DB_W'(DB_MS - 1)) launch = 1'b1;
                    else                              d.db_cnt = q.db_cnt + 1'b1;
                end
            end
            ST_SEND: begin
                if (ms_tick) begin
                    if (q.to_cnt != '1) d.to_cnt = q.to_cnt + 1'b1;
                    if (q.sd_cnt != '1) d.sd_cnt = q.sd_cnt + 1'b1;
                end
                if (btn_new) begin
                    d.abort = 1'b1;
                    launch  = 1'b1;
                end else if (word_done) begin
                    if (q.to_cnt >= to_lim) begin
                        d.st = ST_WAIT_REL;
                    end else if (fin) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.start   = 1'b1;
                        d.wcnt    = wc_nxt;
                        d.rel_cnt = rc_nxt;
                        d.seed    = seed_ok && (prod_on ? (wc_nxt >= min_w)
                                                        : (q.sd_cnt >= sd_lim));
                    end
                end
            end
            ST_WAIT_REL: begin
                if (btn == 4'b0000) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        if (launch) begin
            d.st      = ST_SEND;
            d.code    = btn;
            d.to_cnt  = '0;
            d.sd_cnt  = '0;
            d.wcnt    = '0;
            d.rel_cnt = '0;
            d.start   = 1'b1;
            d.inc     = inc_req;
            d.seed    = seed_ok && !prod_on && (sd_lim == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    tx_led_blinker #(
        .LED_UNIT_MS (LED_UNIT_MS),
        .LED_OFF_MS  (LED_OFF_MS)
    ) u_led (
        .clk           (clk),
        .rst_n         (rst_n),
        .ms_tick       (ms_tick),
        .active        (q.st == ST_SEND),
        .cfg_led_long  (cfg_led_long),
        .batt_low      (batt_low),
        .cfg_blink_low (cfg_blink_low),
        .led_n         (led_n)
    );

    assign word_start = q.start;
    assign word_seed  = q.seed;
    assign word_abort = q.abort;
    assign word_btn   = q.code;
    assign cnt_inc    = q.inc;
    assign rf_en      = cfg_rfen_en && (q.st == ST_SEND);

endmodule

// File: rtl/tx_session_seq_chk.sv
module tx_session_seq_chk #(
    parameter int CNT_W      = 20,
    parameter int SEED_LIMIT = 127
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_done,
    input logic [CNT_W-1:0] sync_cnt,
    input logic [3:0]       cfg_seed_btn,
    input logic             cfg_seed_limit,
    input logic             cfg_rfen_en,
    input logic             word_start,
    input logic             word_seed,
    input logic             word_abort,
    input logic [3:0]       word_btn,
    input logic             cnt_inc,
    input logic             rf_en
);

    a_r10_inc_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_inc |-> word_start);

    a_r5_abort_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        word_abort |-> word_start);

    a_r2_start_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |-> (word_btn != 4'b0000));

    a_r11_rf_off_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rfen_en |-> !rf_en);

    a_r11_rf_falls_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rf_en) && cfg_rfen_en && $past(cfg_rfen_en)) |-> $past(word_done));

    a_r6_seed_matches_field: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start && word_seed) |->
            (($past(cfg_seed_btn) != 4'b0000) && (word_btn == $past(cfg_seed_btn))));

    a_r8_seed_under_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start && word_seed && $past(cfg_seed_limit)) |->
            ($past(sync_cnt) <= CNT_W'(SEED_LIMIT)));

endmodule

bind tx_session_seq tx_session_seq_chk #(
    .CNT_W      (CNT_W),
    .SEED_LIMIT (SEED_LIMIT)
) u_chk (.*);

// File: tb/tx_session_seq_tb.sv
module tx_session_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WLEN       = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick;
    logic [3:0]  btn = 4'b0;
    logic        word_done;
    logic [19:0] sync_cnt = '0;
    logic        batt_low = 1'b0;
    logic [1:0]  cfg_min_words = 2'd0, cfg_timeout = 2'd3, cfg_seed_delay = 2'd0;
    logic [3:0]  cfg_seed_btn = 4'b0;
    logic        cfg_seed_limit = 1'b0, cfg_seed_prod = 1'b0, cfg_rfen_en = 1'b1;
    logic        cfg_led_long = 1'b0, cfg_blink_low = 1'b0;
    logic        word_start, word_seed, word_abort, cnt_inc, rf_en, led_n;
    logic [3:0]  word_btn;

    int n_checks = 0, n_fail = 0;
    int n_start, n_seed, n_abort, n_inc, n_flash;
    logic [15:0] seq_seed;
    logic [3:0]  last_btn;
    logic        rf_seen, led_prev, mon_clr = 1'b0;
    logic [4:0]  mcnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_session_seq #(
        .DB_MS       (3),
        .TO_UNIT_MS  (10),
        .LED_UNIT_MS (2),
        .LED_OFF_MS  (20),
        .CNT_W       (20),
        .SEED_LIMIT  (127)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .btn(btn), .word_done(word_done),
        .sync_cnt(sync_cnt), .batt_low(batt_low), .cfg_min_words(cfg_min_words),
        .cfg_timeout(cfg_timeout), .cfg_seed_btn(cfg_seed_btn), .cfg_seed_delay(cfg_seed_delay),
        .cfg_seed_limit(cfg_seed_limit), .cfg_seed_prod(cfg_seed_prod), .cfg_rfen_en(cfg_rfen_en),
        .cfg_led_long(cfg_led_long), .cfg_blink_low(cfg_blink_low),
        .word_start(word_start), .word_seed(word_seed), .word_abort(word_abort),
        .word_btn(word_btn), .cnt_inc(cnt_inc), .rf_en(rf_en), .led_n(led_n)
    );

    // millisecond tick every second clock
    always @(posedge clk) begin
        if (!rst_n) ms_tick <= 1'b0;
        else        ms_tick <= ~ms_tick;
    end

    // modulator model: each word lasts WLEN clocks
    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt <= '0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (word_start) mcnt <= 5'(WLEN);
            else if (mcnt != 0) begin
                mcnt <= mcnt - 1'b1;
                if (mcnt == 5'd1) word_done <= 1'b1;
            end
        end
    end

    // output monitor
    always @(negedge clk) begin
        if (mon_clr) begin
            n_start = 0; n_seed = 0; n_abort = 0; n_inc = 0; n_flash = 0;
            seq_seed = '0; last_btn = '0; rf_seen = 1'b0; led_prev = 1'b1;
        end else begin
            if (word_start) begin
                if (n_start < 16) seq_seed[n_start] = word_seed;
                n_start = n_start + 1;
                if (word_seed) n_seed = n_seed + 1;
                last_btn = word_btn;
            end
            if (word_abort) n_abort = n_abort + 1;
            if (cnt_inc) n_inc = n_inc + 1;
            if (rf_en) rf_seen = 1'b1;
            if (!led_n && led_prev) n_flash = n_flash + 1;
            led_prev = led_n;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; btn = 4'b0; sync_cnt = '0; batt_low = 1'b0;
        cfg_min_words = 2'd0; cfg_timeout = 2'd3; cfg_seed_btn = 4'b0; cfg_seed_delay = 2'd0;
        cfg_seed_limit = 1'b0; cfg_seed_prod = 1'b0; cfg_rfen_en = 1'b1;
        cfg_led_long = 1'b0; cfg_blink_low = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clr();
    endtask

    task automatic wait_start();
        int i = 0;
        do begin
            @(negedge clk);
            i++;
        end while (!word_start && i < 300);
    endtask

    task automatic press_release(input logic [3:0] code);
        btn = code;
        wait_start();
        btn = 4'b0;
        repeat (200) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R2 reset word_start", int'(word_start), 0);
        check("R2 reset rf_en", int'(rf_en), 0);
        check("R2 reset led_n", int'(led_n), 1);
    endtask

    task automatic t_debounce();
        do_reset();
        btn = 4'b0010;
        repeat (3) @(negedge clk);
        btn = 4'b0;
        repeat (60) @(negedge clk);
        check("R1 short press no word", n_start, 0);
        btn = 4'b0010;
        wait_start();
        check("R2 latched code", int'(word_btn), 2);
        check("R11 rf_en high in session", int'(rf_en), 1);
        btn = 4'b0;
        repeat (200) @(negedge clk);
        check("R1 long press one word", n_start, 1);
        check("R11 rf_en low after session", int'(rf_en), 0);
        check("R10 hop session one increment", n_inc, 1);
    endtask

    task automatic t_min_words(input logic [1:0] sel, input int exp);
        do_reset();
        cfg_min_words = sel;
        press_release(4'b0001);
        check("R3 words after release", n_start, exp);
    endtask

    task automatic t_timeout_held();
        do_reset();
        cfg_timeout = 2'd0;
        btn = 4'b0100;
        wait_start();
        repeat (300) @(negedge clk);
        check("R4 ended while held", int'(rf_en), 0);
        check("R4 few words before time-out", int'(n_start <= 4), 1);
        check("R4 no restart while held", int'(n_start >= 1 && n_start <= 4), 1);
        btn = 4'b0;
        repeat (50) @(negedge clk);
    endtask

    task automatic t_timeout_cuts_min();
        do_reset();
        cfg_timeout = 2'd0;
        cfg_min_words = 2'd3;
        press_release(4'b0001);
        check("R4 minimum cut short", int'(n_start < 8), 1);
    endtask

    task automatic t_abort();
        do_reset();
        cfg_timeout = 2'd0;
        btn = 4'b0001;
        wait_start();
        for (int i = 0; i < 12; i++) begin
            repeat (14) @(negedge clk);
            btn = (btn == 4'b0001) ? 4'b0011 : 4'b0001;
        end
        repeat (2) @(negedge clk);
        check("R5 abort pulses", int'(n_abort >= 10), 1);
        check("R5 time-out window restarted", int'(rf_en), 1);
        check("R5 re-latched code", int'(last_btn), int'(btn));
        btn = 4'b0;
        repeat (200) @(negedge clk);
        check("R5 session ends after release", int'(rf_en), 0);
    endtask

    task automatic t_seed_immediate();
        do_reset();
        cfg_seed_btn = 4'b0101;
        press_release(4'b0101);
        check("R6 seed word on match", int'(seq_seed[0]), 1);
        check("R10 pure seed no increment", n_inc, 0);
        press_release(4'b0001);
        check("R6 no seed on other code", n_seed, 1);
    endtask

    task automatic t_seed_field_zero();
        do_reset();
        cfg_seed_btn = 4'b0000;
        press_release(4'b0101);
        check("R6 field zero disables seeds", n_seed, 0);
    endtask

    task automatic t_seed_delay();
        do_reset();
        cfg_seed_btn = 4'b0101;
        cfg_seed_delay = 2'd1;
        btn = 4'b0101;
        wait_start();
        repeat (120) @(negedge clk);
        btn = 4'b0;
        repeat (200) @(negedge clk);
        check("R7 first word rolling", int'(seq_seed[0]), 0);
        check("R7 seeds after delay", int'(n_seed >= 1), 1);
        check("R10 delayed seed increments", n_inc, 1);
    endtask

    task automatic t_production();
        do_reset();
        cfg_seed_btn = 4'b0101;
        cfg_seed_prod = 1'b1;
        cfg_min_words = 2'd1;
        press_release(4'b0101);
        check("R9 word count", n_start, 4);
        check("R9 rolling then seed", int'(seq_seed[3:0]), 12);
        check("R10 production increments", n_inc, 1);
    endtask

    task automatic t_limit();
        do_reset();
        sync_cnt = 20'd200;
        repeat (3) @(negedge clk);
        sync_cnt = 20'd5;
        cfg_seed_btn = 4'b0101;
        cfg_seed_limit = 1'b1;
        press_release(4'b0101);
        check("R8 seed refused after wrap", int'(seq_seed[0]), 0);
        check("R8 refused seed increments", n_inc, 1);
        clr();
        cfg_seed_limit = 1'b0;
        cfg_seed_prod = 1'b1;
        press_release(4'b0101);
        check("R9 production off past limit", int'(seq_seed[0]), 1);
        check("R9 no increment past limit", n_inc, 0);
    endtask

    task automatic t_rf_disabled();
        do_reset();
        cfg_rfen_en = 1'b0;
        press_release(4'b1000);
        check("R11 rf disabled", int'(rf_seen), 0);
        check("R11 word still sent", n_start, 1);
    endtask

    task automatic t_led(input logic lng);
        do_reset();
        cfg_led_long = lng;
        btn = 4'b0001;
        wait_start();
        @(negedge clk);
        check("R12 led on at start", int'(led_n), 0);
        if (lng) begin
            repeat (5) @(negedge clk);
            check("R12 long on-interval still lit", int'(led_n), 0);
            repeat (10) @(negedge clk);
            check("R12 long on-interval over", int'(led_n), 1);
        end else begin
            repeat (9) @(negedge clk);
            check("R12 short on-interval over", int'(led_n), 1);
            repeat (190) @(negedge clk);
            check("R12 repeated flashes", int'(n_flash >= 3), 1);
        end
        btn = 4'b0;
        repeat (200) @(negedge clk);
        check("R12 led dark after session", int'(led_n), 1);
    endtask

    task automatic t_led_batt(input logic blink, input int exp);
        do_reset();
        batt_low = 1'b1;
        cfg_blink_low = blink;
        btn = 4'b0001;
        wait_start();
        repeat (200) @(negedge clk);
        btn = 4'b0;
        repeat (100) @(negedge clk);
        check("R13 low battery flashes", n_flash, exp);
    endtask

    logic done_flag = 1'b0;

    initial begin
        t_reset_state();
        t_debounce();
        t_min_words(2'd0, 1);
        t_min_words(2'd2, 4);
        t_min_words(2'd3, 8);
        t_timeout_held();
        t_timeout_cuts_min();
        t_abort();
        t_seed_immediate();
        t_seed_field_zero();
        t_seed_delay();
        t_production();
        t_limit();
        t_rf_disabled();
        t_led(1'b0);
        t_led(1'b1);
        t_led_batt(1'b0, 0);
        t_led_batt(1'b1, 1);
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule